// File: doc/BRIEF.md
# SMI Event Flag and Mask Register

This block is a 64-bit configuration register that collects system-management interrupt events from four sources. It also drives two interrupt lines, one for synchronous events and one for asynchronous events. The synchronous events come from the configuration access port: a read of one chosen power-management address, and a write of another. The asynchronous events are a debug strobe, an access of any kind to a processor-status address, and an error pulse from any of several attached devices.

Each source has a mask bit, and the mask bits are active low: a 1 blocks the source and a 0 lets it through. After reset every source is blocked. When an unblocked source fires, its flag latches and holds until software clears it by writing a 1 to that flag. The synchronous line is the OR of the two synchronous flags, and the asynchronous line is the OR of the other two. Software reads and writes the register through the same access port that carries the watched addresses. A read is combinational and has no side effect.

Top module: `smi_evt_reg`

## Requirements
- R1: After reset the register reads 64'h0000_0000_0000_000F and both interrupt lines are low.
- R2: Bits 3:0 are mask bits, one per source: bit 0 error, bit 1 debug, bit 2 counter-address write, bit 3 level-2-address read. While a mask bit is 1, an event from its source leaves its flag and the interrupt lines unchanged.
- R3: A read at address LVL2_ADDR while bit 3 is 0 sets bit 19 and raises smi_sync.
- R4: A write at address CNT_ADDR while bit 2 is 0 sets bit 18 and raises smi_sync.
- R5: A pulse on dbg_evt, or any read or write at STAT_ADDR, while bit 1 is 0 sets bit 17 and raises smi_async.
- R6: A pulse on any line of err_evt while bit 0 is 0 sets bit 16 and raises smi_async.
- R7: Flags in bits 19:16 are sticky. A register write clears each flag whose write-data bit is 1 and leaves each flag whose write-data bit is 0 unchanged.
- R8: When an unmasked event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Bits 63:20 and 15:4 read back the last value written to them and have no effect on flags or interrupt lines.
- R10: Writing the mask bits leaves flags that are already set unchanged.
- R11: smi_sync is high exactly when bit 18 or bit 19 is set, and smi_async is high exactly when bit 16 or bit 17 is set. A line rises on the clock edge that captures the event, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd | input | 1 | Read strobe of the access port |
| cfg_wr | input | 1 | Write strobe of the access port |
| cfg_addr | input | ADDR_W | Access address |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Register contents when cfg_rd addresses SELF_ADDR, else zero |
| dbg_evt | input | 1 | Single-cycle debug event strobe |
| err_evt | input | N_ERR | Single-cycle error pulses, one per attached device |
| smi_sync | output | 1 | Synchronous SMI request |
| smi_async | output | 1 | Asynchronous SMI request |

## Verification
Any error in the flag or mask state shows up at the ports in the next cycle. It appears as a wrong value on a readback of SELF_ADDR, or as a wrong level on smi_sync or smi_async. A flag lost to a masking slip, or cleared by a write of 0, leaves an interrupt line low one cycle after the event. A wrongly latched flag raises a line that only a clearing write can lower. Corrupted reserved bits appear on the very next readback.

// File: rtl/smi_evt_pkg.sv
package smi_evt_pkg;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned NSRC     = 4;
  localparam int unsigned EN_LSB   = 0;
  localparam int unsigned RLO_LSB  = EN_LSB + NSRC;
  localparam int unsigned FLAG_LSB = 16;
  localparam int unsigned RLO_W    = FLAG_LSB - RLO_LSB;
  localparam int unsigned RHI_LSB  = FLAG_LSB + NSRC;
  localparam int unsigned RHI_W    = REG_W - RHI_LSB;

  typedef enum logic [1:0] {
    SRC_ERR  = 2'd0,
    SRC_DBG  = 2'd1,
    SRC_CNT  = 2'd2,
    SRC_LVL2 = 2'd3
  } smi_src_e;

  localparam logic [NSRC-1:0] SYNC_GROUP  = 4'b1100;
  localparam logic [NSRC-1:0] ASYNC_GROUP = 4'b0011;
  localparam logic [NSRC-1:0] MASK_RESET  = '1;

  // An event wins over a clear in the same cycle.
  function automatic logic [NSRC-1:0] flag_next(
    input logic [NSRC-1:0] cur,
    input logic [NSRC-1:0] clr,
    input logic [NSRC-1:0] hit,
    input logic [NSRC-1:0] mask_n
  );
    return (cur & ~clr) | (hit & ~mask_n);
  endfunction

  function automatic logic [REG_W-1:0] pack_word(
    input logic [NSRC-1:0]  mask_n,
    input logic [RLO_W-1:0] rlo,
    input logic [NSRC-1:0]  flags,
    input logic [RHI_W-1:0] rhi
  );
    return {rhi, flags, rlo, mask_n};
  endfunction

  function automatic logic group_any(
    input logic [NSRC-1:0] flags,
    input logic [NSRC-1:0] grp
  );
    return |(flags & grp);
  endfunction
endpackage

// File: rtl/smi_evt_decode.sv
module smi_evt_decode
  import smi_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned N_ERR  = 4,
  parameter logic [ADDR_W-1:0] LVL2_ADDR = 'h119,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 'h118,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h10D
) (
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              dbg_evt,
  input  logic [N_ERR-1:0]  err_evt,
  output logic [NSRC-1:0]   src_hit,
  output logic              sync_hit,
  output logic              async_hit
);
  logic lvl2_rd, cnt_wr, stat_acc, err_any;

  assign lvl2_rd  = cfg_rd && (cfg_addr == LVL2_ADDR);
  assign cnt_wr   = cfg_wr && (cfg_addr == CNT_ADDR);
  assign stat_acc = (cfg_rd || cfg_wr) && (cfg_addr == STAT_ADDR);
  assign err_any  = |err_evt;

  always_comb begin
    src_hit = '0;
    src_hit[int'(SRC_ERR)]  = err_any;
    src_hit[int'(SRC_DBG)]  = dbg_evt || stat_acc;
    src_hit[int'(SRC_CNT)]  = cnt_wr;
    src_hit[int'(SRC_LVL2)] = lvl2_rd;
  end

  assign sync_hit  = group_any(src_hit, SYNC_GROUP);
  assign async_hit = group_any(src_hit, ASYNC_GROUP);

  always_comb begin
    assert (!(lvl2_rd && cnt_wr)) else $error("AST_ONE_ADDR"); // R3
  end
endmodule

// File: rtl/smi_evt_ctrl_store.sv
module smi_evt_ctrl_store
  import smi_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_self,
  input  logic [NSRC-1:0]  mask_wd,
  input  logic [RLO_W-1:0] rlo_wd,
  input  logic [RHI_W-1:0] rhi_wd,
  output logic [NSRC-1:0]  mask_n,
  output logic [RLO_W-1:0] rlo_q,
  output logic [RHI_W-1:0] rhi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_n <= MASK_RESET;
      rlo_q  <= '0;
      rhi_q  <= '0;
    end else if (wr_self) begin
      mask_n <= mask_wd;
      rlo_q  <= rlo_wd;
      rhi_q  <= rhi_wd;
    end
  end

  AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_self |=> (rlo_q == $past(rlo_wd)) && (rhi_q == $past(rhi_wd))); // R9
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_self |=> $stable(mask_n)); // R2
endmodule

// File: rtl/smi_evt_flags.sv
module smi_evt_flags
  import smi_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flag_clr,
  input  logic [NSRC-1:0] src_hit,
  input  logic [NSRC-1:0] mask_n,
  output logic [NSRC-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flag_next(flags, flag_clr, src_hit, mask_n);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && (!src_hit[i] || mask_n[i])) |=> !flags[i]); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !flag_clr[i]) |=> flags[i]); // R7
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (src_hit[i] && !mask_n[i]) |=> flags[i]); // R8
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !(src_hit[i] && !mask_n[i])) |=> !flags[i]); // R7
  end
endmodule

// File: rtl/smi_evt_reg.sv
module smi_evt_reg
  import smi_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned N_ERR  = 4,
  parameter logic [ADDR_W-1:0] SELF_ADDR = 'h100,
  parameter logic [ADDR_W-1:0] LVL2_ADDR = 'h119,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 'h118,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h10D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              dbg_evt,
  input  logic [N_ERR-1:0]  err_evt,
  output logic              smi_sync,
  output logic              smi_async
);
  logic              wr_self, rd_self;
  logic [NSRC-1:0]   src_hit, mask_n, flags, flag_clr;
  logic              sync_hit, async_hit;
  logic [RLO_W-1:0]  rlo_q;
  logic [RHI_W-1:0]  rhi_q;
  logic [REG_W-1:0]  reg_word;

  assign wr_self  = cfg_wr && (cfg_addr == SELF_ADDR);
  assign rd_self  = cfg_rd && (cfg_addr == SELF_ADDR);
  assign flag_clr = wr_self ? cfg_wdata[FLAG_LSB +: NSRC] : '0;

  smi_evt_decode #(
    .ADDR_W(ADDR_W), .N_ERR(N_ERR),
    .LVL2_ADDR(LVL2_ADDR), .CNT_ADDR(CNT_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_dec (
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .dbg_evt(dbg_evt), .err_evt(err_evt),
    .src_hit(src_hit), .sync_hit(sync_hit), .async_hit(async_hit)
  );

  smi_evt_ctrl_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_self(wr_self),
    .mask_wd(cfg_wdata[EN_LSB +: NSRC]),
    .rlo_wd(cfg_wdata[RLO_LSB +: RLO_W]),
    .rhi_wd(cfg_wdata[RHI_LSB +: RHI_W]),
    .mask_n(mask_n), .rlo_q(rlo_q), .rhi_q(rhi_q)
  );

  smi_evt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr),
    .src_hit(src_hit), .mask_n(mask_n), .flags(flags)
  );

  assign reg_word  = pack_word(mask_n, rlo_q, flags, rhi_q);
  assign cfg_rdata = rd_self ? reg_word : '0;
  assign smi_sync  = group_any(flags, SYNC_GROUP);
  assign smi_async = group_any(flags, ASYNC_GROUP);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!smi_sync && !smi_async)); // R1
  AST_SYNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_sync) |-> $past(sync_hit)); // R11
  AST_ASYNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_async) |-> $past(async_hit)); // R11
  AST_MASK_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_self && (cfg_wdata[FLAG_LSB +: NSRC] == '0)) |=> ((flags & $past(flags)) == $past(flags))); // R10
endmodule

// File: tb/smi_evt_reg_tb_top.sv
module smi_evt_reg_tb_top;
  localparam logic [31:0] SELF = 32'h100;
  localparam logic [31:0] LVL2 = 32'h119;
  localparam logic [31:0] CNT  = 32'h118;
  localparam logic [31:0] STAT = 32'h10D;

  localparam logic [2:0] OP_NOP = 3'd0, OP_WR = 3'd1, OP_LVL2 = 3'd2, OP_CNT = 3'd3,
                         OP_STAT = 3'd4, OP_DBG = 3'd5, OP_ERR = 3'd6;
  localparam int NV = 20;
  // {op, data, expected readback, expected {sync, async}}
  localparam logic [132:0] VEC [NV] = '{
    {OP_NOP,  64'h0, 64'h0000_0000_0000_000F, 2'b00},
    {OP_LVL2, 64'h0, 64'h0000_0000_0000_000F, 2'b00},
    {OP_DBG,  64'h0, 64'h0000_0000_0000_000F, 2'b00},
    {OP_ERR,  64'h1, 64'h0000_0000_0000_000F, 2'b00},
    {OP_WR,   64'h0, 64'h0000_0000_0000_0000, 2'b00},
    {OP_LVL2, 64'h0, 64'h0000_0000_0008_0000, 2'b10},
    {OP_WR,   64'h0000_0000_0008_0000, 64'h0, 2'b00},
    {OP_CNT,  64'h0, 64'h0000_0000_0004_0000, 2'b10},
    {OP_WR,   64'h0, 64'h0000_0000_0004_0000, 2'b10},
    {OP_DBG,  64'h0, 64'h0000_0000_0006_0000, 2'b11},
    {OP_WR,   64'h0000_0000_0006_0000, 64'h0, 2'b00},
    {OP_STAT, 64'h0, 64'h0000_0000_0002_0000, 2'b01},
    {OP_ERR,  64'h4, 64'h0000_0000_0003_0000, 2'b01},
    {OP_WR,   64'hF, 64'h0000_0000_0003_000F, 2'b01},
    {OP_WR,   64'h0000_0000_0003_000F, 64'h0000_0000_0000_000F, 2'b00},
    {OP_WR,   64'hFFFF_FFFF_FFF0_FFF7, 64'hFFFF_FFFF_FFF0_FFF7, 2'b00},
    {OP_CNT,  64'h0, 64'hFFFF_FFFF_FFF0_FFF7, 2'b00},
    {OP_LVL2, 64'h0, 64'hFFFF_FFFF_FFF8_FFF7, 2'b10},
    {OP_WR,   64'h0, 64'h0000_0000_0008_0000, 2'b10},
    {OP_WR,   64'h0000_0000_0008_0000, 64'h0, 2'b00}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R1";
      1, 2, 3, 16: return "R2";
      5: return "R3";
      7: return "R4";
      9, 11: return "R5";
      12: return "R6";
      6, 8, 10, 19: return "R7";
      13, 14: return "R10";
      15, 17: return "R9";
      default: return "R11";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic [31:0] cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        dbg_evt = 1'b0;
  logic [3:0]  err_evt = '0;
  logic        smi_sync, smi_async;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  smi_evt_reg dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dbg_evt(dbg_evt), .err_evt(err_evt), .smi_sync(smi_sync), .smi_async(smi_async)
  );

  task automatic idle();
    cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    dbg_evt = 1'b0; err_evt = '0;
  endtask

  task automatic drive(input logic [2:0] op, input logic [63:0] d);
    idle();
    case (op)
      OP_WR:   begin cfg_wr = 1'b1; cfg_addr = SELF; cfg_wdata = d; end
      OP_LVL2: begin cfg_rd = 1'b1; cfg_addr = LVL2; end
      OP_CNT:  begin cfg_wr = 1'b1; cfg_addr = CNT; cfg_wdata = d; end
      OP_STAT: begin cfg_rd = 1'b1; cfg_addr = STAT; end
      OP_DBG:  dbg_evt = 1'b1;
      OP_ERR:  err_evt = d[3:0];
      default: ;
    endcase
  endtask

  // Next negedge: drop stimulus, read own register, sample.
  task automatic settle_read();
    @(negedge clk);
    idle();
    cfg_rd = 1'b1; cfg_addr = SELF;
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] exp_d, input logic [1:0] exp_o);
    n_chk++;
    if (cfg_rdata !== exp_d || {smi_sync, smi_async} !== exp_o) begin
      n_bad++;
      $display("FAIL %s: rdata=%h sync/async=%b expected rdata=%h sync/async=%b",
               req, cfg_rdata, {smi_sync, smi_async}, exp_d, exp_o);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp_b);
    n_chk++;
    if (act !== exp_b) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp_b);
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][132:130], VEC[i][129:66]);
      settle_read();
      check(tag_of(i), VEC[i][65:2], VEC[i][1:0]);
    end

    // R6: each error line on its own
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      drive(OP_ERR, 64'(1) << k);
      settle_read();
      check("R6", 64'h0000_0000_0001_0000, 2'b01);
      @(negedge clk);
      drive(OP_WR, 64'h0000_0000_0001_0000);
      settle_read();
      check("R7", 64'h0, 2'b00);
    end

    // R8: set debug flag, then event and clearing write together
    @(negedge clk); drive(OP_DBG, 64'h0);
    settle_read();
    @(negedge clk);
    drive(OP_WR, 64'h0000_0000_0002_0000);
    dbg_evt = 1'b1;
    settle_read();
    check("R8", 64'h0000_0000_0002_0000, 2'b01);
    @(negedge clk); drive(OP_WR, 64'h0000_0000_0002_0000);
    settle_read();
    check("R7", 64'h0, 2'b00);

    // R11: line stays low until the capturing edge
    @(negedge clk); drive(OP_CNT, 64'h0);
    #1;
    check_bit("R11", smi_sync, 1'b0);
    settle_read();
    check("R11", 64'h0000_0000_0004_0000, 2'b10);

    // R5: a write to the status address also counts
    @(negedge clk); drive(OP_STAT, 64'h0);
    cfg_rd = 1'b0; cfg_wr = 1'b1;
    settle_read();
    check("R5", 64'h0000_0000_0006_0000, 2'b11);

    // R1: reset mid-run with flags set
    @(negedge clk); idle(); rst_n = 1'b0;
    #1;
    check_bit("R1", smi_sync | smi_async, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cfg_rd = 1'b1; cfg_addr = SELF;
    #1;
    check("R1", 64'h0000_0000_0000_000F, 2'b00);

    @(negedge clk); idle();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule